// File: doc/BRIEF.md
# Sliding-Window Residual Mean and Variance Detector

This block watches a stream of signed residual samples, each being the difference between a measured quantity and a model's prediction of it. It keeps the most recent `WIN` accepted samples in a circular store. On every accepted sample it updates two indicators over that window. The first is a first-moment indicator, which rises under a slow bias. The second is a second-moment indicator, which rises under injected noise. A programmed steady-state baseline is removed from each indicator. The magnitude of each result is then compared against its own threshold. A hit sets a sticky alarm flag for that indicator, and a combined flag is the OR of the two.

To avoid dividing by a window length that is not a power of two, both indicators are kept at a fixed scale. The first indicator is the window sum, which equals `WIN` times the mean. The second is `WIN*Σx² − (Σx)²`, which equals `WIN²` times the population variance. Baselines and thresholds are given in these same units. Thresholds can be written directly. They can also be derived by a calibration session: while calibration is enabled, the block records the largest baseline-removed magnitude of each indicator, and when calibration ends it loads each threshold with three times that peak.

Top module: `resid_window_detector`

## Requirements
- R1: `win_ready` is 0 after reset. It rises one cycle after the clock edge that accepts the `WIN`-th sample (`res_valid` high) and then stays 1 until reset.
- R2: `ind_mean` equals the sum of the last min(accepted, `WIN`) accepted samples minus `base_mean`. It updates one cycle after each accepted sample. Cycles with `res_valid` low leave the window unchanged.
- R3: `ind_var` equals `WIN*Σx² − (Σx)² − base_var`, with both sums taken over the same samples as R2. It stays exact for all-extreme inputs (-2^(DATA_W-1) and 2^(DATA_W-1)-1).
- R4: On a clock edge where `win_ready` is 1, `cal_en` is 0, and |indicator| is strictly greater than that indicator's threshold, the indicator's alarm flag is 1 from the next cycle on.
- R5: An alarm flag stays set until `alarm_clr` is high at a clock edge. `alarm_clr` clears both flags and takes priority over a new hit at that same edge.
- R6: `alarm_any` is 1 exactly when `alarm_mean` or `alarm_var` is 1.
- R7: After reset both thresholds are all ones. A clock edge with `thr_we` high loads `thr_mean` and `thr_var` from their write-data ports. Otherwise the thresholds hold, except as stated in R8.
- R8: Each clock edge with `cal_en` high and `win_ready` high keeps, per indicator, the largest |indicator| seen in the current session. A session's peak starts from zero. On the first edge with `cal_en` low after a high one, each threshold becomes 3 times its peak, and this overrides `thr_we`.
- R9: No alarm flag becomes set at an edge where `cal_en` is high or `win_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Residual sample strobe |
| res_data | input | DATA_W | Signed residual sample |
| base_mean | input | IND_W | Signed baseline removed from the first indicator |
| base_var | input | IND_W | Signed baseline removed from the second indicator |
| cal_en | input | 1 | Calibration session enable |
| thr_we | input | 1 | Threshold write strobe |
| thr_mean_wdata | input | THR_W | Threshold value for the first indicator |
| thr_var_wdata | input | THR_W | Threshold value for the second indicator |
| alarm_clr | input | 1 | Clears both alarm flags |
| win_ready | output | 1 | Window has been filled once |
| ind_mean | output | IND_W+1 | Baseline-removed first indicator, signed |
| ind_var | output | IND_W+1 | Baseline-removed second indicator, signed |
| thr_mean | output | THR_W | Current first-indicator threshold |
| thr_var | output | THR_W | Current second-indicator threshold |
| alarm_mean | output | 1 | Sticky alarm for the first indicator |
| alarm_var | output | 1 | Sticky alarm for the second indicator |
| alarm_any | output | 1 | OR of both alarms |

## Verification
The bench goes after the window edge. It gaps the strobe so that a design counting cycles instead of samples fills early, and it runs well past `WIN` samples, so a design that evicts the wrong entry, or evicts before the store is full, drifts from the reference sum. It fills the window with full-scale negative samples and then with alternating extremes, which exposes accumulators or products that are too narrow, because the second indicator then ceases to be zero or exact. It also checks clear-versus-hit priority while a bias is still present. It holds calibration open under a bias attack: a design that lets alarms through during calibration raises a flag it should not. At the end of each session it checks the threshold against three times the peak magnitude, which catches a peak that keeps its value from an earlier session or that takes a signed maximum in place of the magnitude.

// File: rtl/rwd_pkg.sv
package rwd_pkg;

   typedef enum int unsigned {
      IND_MEAN = 0,
      IND_VAR  = 1
   } ind_e;

   localparam int NUM_IND = 2;

   // width of the sample counter for a window of win entries
   function automatic int cnt_w(input int win);
      return $clog2(win + 1);
   endfunction

   // signed width holding WIN*sum(x^2) - sum(x)^2 without wrap
   function automatic int ind_w(input int dw, input int win);
      return 2 * dw + 2 * cnt_w(win) + 1;
   endfunction

endpackage

// File: rtl/rwd_window.sv
module rwd_window #(
   parameter int DATA_W = 16,
   parameter int WIN    = 500
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic signed [DATA_W-1:0] din,
   output logic signed [DATA_W-1:0] oldest,
   output logic                     full
);
   localparam int PW = (WIN > 1) ? $clog2(WIN) : 1;
   localparam int CW = rwd_pkg::cnt_w(WIN);

   logic signed [DATA_W-1:0] store [WIN];
   logic [PW-1:0]            wptr;
   logic [CW-1:0]            fill;

   assign full   = (fill == CW'(WIN));
   // before the store is full nothing leaves the window
   assign oldest = full ? store[wptr] : '0;

   always_ff @(posedge clk) begin
      if (push) begin
         store[wptr] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         fill <= '0;
      end else if (push) begin
         wptr <= (wptr == PW'(WIN - 1)) ? '0 : wptr + 1'b1;
         if (!full) begin
            fill <= fill + 1'b1;
         end
      end
   end

endmodule

// File: rtl/rwd_sums.sv
module rwd_sums #(
   parameter int DATA_W = 16,
   parameter int WIN    = 500,
   localparam int CW    = rwd_pkg::cnt_w(WIN),
   localparam int SUM_W = DATA_W + CW,
   localparam int SQ_W  = 2 * DATA_W + CW
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic signed [DATA_W-1:0] din,
   input  logic signed [DATA_W-1:0] oldest,
   output logic signed [SUM_W-1:0]  sum,
   output logic        [SQ_W-1:0]   sumsq
);
   logic signed [2*DATA_W-1:0] din_x, old_x;
   logic signed [2*DATA_W-1:0] sq_in_s, sq_out_s;

   assign din_x    = din;
   assign old_x    = oldest;
   assign sq_in_s  = din_x * din_x;
   assign sq_out_s = old_x * old_x;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum   <= '0;
         sumsq <= '0;
      end else if (push) begin
         sum   <= sum + SUM_W'(din) - SUM_W'(oldest);
         sumsq <= sumsq + SQ_W'($unsigned(sq_in_s)) - SQ_W'($unsigned(sq_out_s));
      end
   end

endmodule

// File: rtl/rwd_lane.sv
module rwd_lane #(
   parameter int IND_W = 51,
   localparam int THR_W = IND_W + 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [IND_W-1:0] value,
   input  logic signed [IND_W-1:0] baseline,
   input  logic                    ready,
   input  logic                    cal_en,
   input  logic                    cal_exit,
   input  logic                    clr,
   input  logic                    thr_we,
   input  logic [THR_W-1:0]        thr_wdata,
   output logic signed [IND_W:0]   excess,
   output logic [THR_W-1:0]        thr,
   output logic                    alarm
);
   logic [IND_W:0] mag;
   logic [IND_W:0] peak;
   logic           hit;

   assign excess = {value[IND_W-1], value} - {baseline[IND_W-1], baseline};
   assign mag    = excess[IND_W] ? (~excess + 1'b1) : excess;
   assign hit    = ready && !cal_en && ({2'b00, mag} > thr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         peak  <= '0;
         thr   <= '1;
         alarm <= 1'b0;
      end else begin
         if (!cal_en) begin
            peak <= '0;
         end else if (ready && (mag > peak)) begin
            peak <= mag;
         end

         if (cal_exit) begin
            thr <= ({2'b00, peak} << 1) + {2'b00, peak};
         end else if (thr_we) begin
            thr <= thr_wdata;
         end

         if (clr) begin
            alarm <= 1'b0;
         end else if (hit) begin
            alarm <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/resid_window_detector.sv
module resid_window_detector #(
   parameter int DATA_W = 16,
   parameter int WIN    = 500,
   localparam int CW    = rwd_pkg::cnt_w(WIN),
   localparam int SUM_W = DATA_W + CW,
   localparam int SQ_W  = 2 * DATA_W + CW,
   localparam int IND_W = rwd_pkg::ind_w(DATA_W, WIN),
   localparam int THR_W = IND_W + 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     res_valid,
   input  logic signed [DATA_W-1:0] res_data,
   input  logic signed [IND_W-1:0]  base_mean,
   input  logic signed [IND_W-1:0]  base_var,
   input  logic                     cal_en,
   input  logic                     thr_we,
   input  logic [THR_W-1:0]         thr_mean_wdata,
   input  logic [THR_W-1:0]         thr_var_wdata,
   input  logic                     alarm_clr,
   output logic                     win_ready,
   output logic signed [IND_W:0]    ind_mean,
   output logic signed [IND_W:0]    ind_var,
   output logic [THR_W-1:0]         thr_mean,
   output logic [THR_W-1:0]         thr_var,
   output logic                     alarm_mean,
   output logic                     alarm_var,
   output logic                     alarm_any
);
   import rwd_pkg::*;

   if (WIN < 2) begin : g_bad_win
      $error("WIN must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_dw
      $error("DATA_W must be at least 2");
   end

   localparam logic signed [IND_W-1:0] WIN_X = IND_W'(WIN);

   logic signed [DATA_W-1:0] oldest;
   logic signed [SUM_W-1:0]  sum;
   logic [SQ_W-1:0]          sumsq;
   logic                     cal_q;
   logic                     cal_exit;
   logic signed [IND_W-1:0]  sum_x, sq_x;

   logic signed [IND_W-1:0] lane_val  [NUM_IND];
   logic signed [IND_W-1:0] lane_base [NUM_IND];
   logic [THR_W-1:0]        lane_wd   [NUM_IND];
   logic signed [IND_W:0]   lane_exc  [NUM_IND];
   logic [THR_W-1:0]        lane_thr  [NUM_IND];
   logic                    lane_alm  [NUM_IND];

   rwd_window #(.DATA_W(DATA_W), .WIN(WIN)) u_window (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (res_valid),
      .din    (res_data),
      .oldest (oldest),
      .full   (win_ready)
   );

   rwd_sums #(.DATA_W(DATA_W), .WIN(WIN)) u_sums (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (res_valid),
      .din    (res_data),
      .oldest (oldest),
      .sum    (sum),
      .sumsq  (sumsq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cal_q <= 1'b0;
      end else begin
         cal_q <= cal_en;
      end
   end
   assign cal_exit = cal_q && !cal_en;

   assign sum_x = IND_W'(sum);
   assign sq_x  = IND_W'(sumsq);

   assign lane_val[IND_MEAN]  = sum_x;
   assign lane_val[IND_VAR]   = WIN_X * sq_x - sum_x * sum_x;
   assign lane_base[IND_MEAN] = base_mean;
   assign lane_base[IND_VAR]  = base_var;
   assign lane_wd[IND_MEAN]   = thr_mean_wdata;
   assign lane_wd[IND_VAR]    = thr_var_wdata;

   for (genvar g = 0; g < NUM_IND; g++) begin : g_lane
      rwd_lane #(.IND_W(IND_W)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .value     (lane_val[g]),
         .baseline  (lane_base[g]),
         .ready     (win_ready),
         .cal_en    (cal_en),
         .cal_exit  (cal_exit),
         .clr       (alarm_clr),
         .thr_we    (thr_we),
         .thr_wdata (lane_wd[g]),
         .excess    (lane_exc[g]),
         .thr       (lane_thr[g]),
         .alarm     (lane_alm[g])
      );
   end

   assign ind_mean   = lane_exc[IND_MEAN];
   assign ind_var    = lane_exc[IND_VAR];
   assign thr_mean   = lane_thr[IND_MEAN];
   assign thr_var    = lane_thr[IND_VAR];
   assign alarm_mean = lane_alm[IND_MEAN];
   assign alarm_var  = lane_alm[IND_VAR];
   assign alarm_any  = alarm_mean | alarm_var;

endmodule

// File: rtl/rwd_checker.sv
module rwd_checker #(
   parameter int THR_W = 54
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cal_en,
   input logic             cal_q,
   input logic             thr_we,
   input logic             alarm_clr,
   input logic             win_ready,
   input logic             alarm_mean,
   input logic             alarm_var,
   input logic [THR_W-1:0] thr_mean,
   input logic [THR_W-1:0] thr_var
);

   assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      win_ready |=> win_ready);

   assert_mean_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_mean && !alarm_clr) |=> alarm_mean);

   assert_var_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_var && !alarm_clr) |=> alarm_var);

   assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_clr |=> (!alarm_mean && !alarm_var));

   assert_mean_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_mean) |-> $past(win_ready && !cal_en));

   assert_var_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_var) |-> $past(win_ready && !cal_en));

   assert_thr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!thr_we && !(cal_q && !cal_en)) |=> ($stable(thr_mean) && $stable(thr_var)));

endmodule

bind resid_window_detector rwd_checker #(.THR_W(THR_W)) u_rwd_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .cal_en     (cal_en),
   .cal_q      (cal_q),
   .thr_we     (thr_we),
   .alarm_clr  (alarm_clr),
   .win_ready  (win_ready),
   .alarm_mean (alarm_mean),
   .alarm_var  (alarm_var),
   .thr_mean   (thr_mean),
   .thr_var    (thr_var)
);

// File: tb/tb_resid_window_detector.sv
module tb_resid_window_detector;
   localparam int DATA_W = 16;
   localparam int WIN    = 500;
   localparam int CW     = $clog2(WIN + 1);
   localparam int IND_W  = 2 * DATA_W + 2 * CW + 1;
   localparam int THR_W  = IND_W + 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic res_valid = 1'b0;
   logic signed [DATA_W-1:0] res_data = '0;
   logic signed [IND_W-1:0]  base_mean = '0;
   logic signed [IND_W-1:0]  base_var = '0;
   logic cal_en = 1'b0, thr_we = 1'b0, alarm_clr = 1'b0;
   logic [THR_W-1:0] thr_mean_wdata = '0, thr_var_wdata = '0;
   logic win_ready, alarm_mean, alarm_var, alarm_any;
   logic signed [IND_W:0] ind_mean, ind_var;
   logic [THR_W-1:0] thr_mean, thr_var;

   always #5 clk = ~clk;

   resid_window_detector #(.DATA_W(DATA_W), .WIN(WIN)) dut (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
      .base_mean(base_mean), .base_var(base_var), .cal_en(cal_en),
      .thr_we(thr_we), .thr_mean_wdata(thr_mean_wdata),
      .thr_var_wdata(thr_var_wdata), .alarm_clr(alarm_clr),
      .win_ready(win_ready), .ind_mean(ind_mean), .ind_var(ind_var),
      .thr_mean(thr_mean), .thr_var(thr_var), .alarm_mean(alarm_mean),
      .alarm_var(alarm_var), .alarm_any(alarm_any)
   );

   // behavioural reference state
   int     q[$];
   longint m_thr_m, m_thr_v, m_peak_m, m_peak_v;
   bit     m_alm_m, m_alm_v, m_cal_q;
   int     checks = 0, fails = 0;
   int unsigned seed = 32'h1234_5678;
   bit     done = 1'b0;

   localparam longint THR_ONES = (longint'(1) << THR_W) - 1;

   function automatic longint absl(input longint x);
      return (x < 0) ? -x : x;
   endfunction

   function automatic longint ref_mean();
      longint s = 0;
      foreach (q[i]) s += q[i];
      return s - longint'(base_mean);
   endfunction

   function automatic longint ref_var();
      longint s = 0, ss = 0;
      foreach (q[i]) begin
         s  += q[i];
         ss += longint'(q[i]) * q[i];
      end
      return longint'(WIN) * ss - s * s - longint'(base_var);
   endfunction

   function automatic int noise(input int amp);
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'(seed[23:8] % (2 * amp + 1)) - amp;
   endfunction

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   task automatic compare_all();
      check("R1 win_ready", longint'(win_ready), longint'(q.size() == WIN));
      check("R2 ind_mean", longint'(ind_mean), ref_mean());
      check("R3 ind_var", longint'(ind_var), ref_var());
      check("R4/R5/R9 alarm_mean", longint'(alarm_mean), longint'(m_alm_m));
      check("R4/R5/R9 alarm_var", longint'(alarm_var), longint'(m_alm_v));
      check("R6 alarm_any", longint'(alarm_any), longint'(alarm_mean | alarm_var));
      check("R7/R8 thr_mean", longint'(thr_mean), m_thr_m);
      check("R7/R8 thr_var", longint'(thr_var), m_thr_v);
   endtask

   // one clock: drive at negedge, update reference at posedge, compare at next negedge
   task automatic step(input bit v, input int d, input bit cal, input bit clr,
                       input bit we, input longint wm, input longint wv);
      longint em, ev, old_pm, old_pv;
      bit rdy;
      res_valid = v; res_data = DATA_W'(d); cal_en = cal; alarm_clr = clr;
      thr_we = we; thr_mean_wdata = THR_W'(wm); thr_var_wdata = THR_W'(wv);
      @(posedge clk);
      rdy = (q.size() == WIN);
      em = absl(ref_mean()); ev = absl(ref_var());
      old_pm = m_peak_m; old_pv = m_peak_v;
      if (clr) begin m_alm_m = 0; m_alm_v = 0; end
      else begin
         if (rdy && !cal && em > m_thr_m) m_alm_m = 1;
         if (rdy && !cal && ev > m_thr_v) m_alm_v = 1;
      end
      if (!cal) begin m_peak_m = 0; m_peak_v = 0; end
      else if (rdy) begin
         if (em > m_peak_m) m_peak_m = em;
         if (ev > m_peak_v) m_peak_v = ev;
      end
      if (m_cal_q && !cal) begin m_thr_m = 3 * old_pm; m_thr_v = 3 * old_pv; end
      else if (we) begin m_thr_m = wm; m_thr_v = wv; end
      m_cal_q = cal;
      if (v) begin
         q.push_back(d);
         if (q.size() > WIN) void'(q.pop_front());
      end
      @(negedge clk);
      if (!done) compare_all();
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      m_thr_m = THR_ONES; m_thr_v = THR_ONES;
      m_peak_m = 0; m_peak_v = 0; m_alm_m = 0; m_alm_v = 0; m_cal_q = 0;
      repeat (4) @(negedge clk);
      compare_all();                                   // R1 R7 reset state
      rst_n = 1'b1;
      @(negedge clk);
      compare_all();

      // R1 R2 R3: gapped fill past the window length
      for (int i = 0; i < 620; i++) step((i % 7) != 3, noise(200), 0, 0, 0, 0, 0);

      // R8: calibration with baselines near the nominal level
      base_mean = IND_W'(longint'(ind_mean) + longint'(base_mean));
      base_var  = IND_W'(longint'(ind_var) + longint'(base_var));
      for (int i = 0; i < 300; i++) step(1, noise(200), 1, 0, 0, 0, 0);
      step(1, noise(200), 0, 0, 1, 5, 5);              // R8 overrides thr_we
      for (int i = 0; i < 200; i++) step(1, noise(200), 0, 0, 0, 0, 0);

      // R4: slow bias drives the first indicator
      for (int i = 0; i < 500; i++) step(1, noise(200) + 2500, 0, 0, 0, 0, 0);
      // R5: clear under a persisting hit, then re-set
      step(1, noise(200) + 2500, 0, 1, 0, 0, 0);
      step(1, noise(200) + 2500, 0, 0, 0, 0, 0);
      step(1, noise(200) + 2500, 0, 0, 0, 0, 0);

      // R9: calibration held open during the bias, no alarm may set
      step(1, noise(200) + 2500, 0, 1, 0, 0, 0);
      for (int i = 0; i < 100; i++) step(1, noise(200) + 2500, 1, 0, 0, 0, 0);
      step(1, noise(200), 0, 1, 0, 0, 0);              // R8 exit from a biased session

      // R7: direct threshold write, then noisy attack on the second indicator
      step(1, noise(200), 0, 1, 1, 64'd3000000, 64'd400000000000);
      for (int i = 0; i < 500; i++) step(1, noise(200), 0, 0, 0, 0, 0);
      step(1, 0, 0, 1, 0, 0, 0);
      for (int i = 0; i < 500; i++) step(1, noise(9000), 0, 0, 0, 0, 0);

      // R3: full-scale windows
      base_mean = '0; base_var = '0;
      for (int i = 0; i < 500; i++) step(1, -32768, 0, 0, 0, 0, 0);
      for (int i = 0; i < 500; i++) step(1, (i % 2) ? 32767 : -32768, 0, 0, 0, 0, 0);
      // R2: idle strobes leave the window alone
      for (int i = 0; i < 20; i++) step(0, 1000, 0, 0, 0, 0, 0);
      finish_run();
   end

endmodule